// File: doc/BRIEF.md
# Dual 40-Bit Accumulator Add/Subtract Unit

This block keeps two 40-bit accumulators and runs one arithmetic, compare or
transfer operation per clock on them. An operation arrives already decoded: an
opcode, a one-bit destination accumulator select and a two-bit source select.
Its second operand comes from the other accumulator, from one of two 32-bit
secondary registers or one of their 16-bit halves, from a 40-bit product input,
or from a 16-bit or 8-bit immediate.

Narrow signed operands (register halves and immediates) are aligned to the
middle word of the accumulator, bits 31:16, so that 16-bit fixed-point values
line up with the accumulator's integer part. After each operation the unit
presents the 40-bit result and five status flags: carry, overflow, zero, sign,
and a flag saying that the result no longer fits a signed 32-bit value.
Compares compute the flags from the full 40-bit difference without writing
either accumulator.

Top module: `acc_arith_unit`

## Requirements
- R1: While reset is asserted (active low) both accumulators and the result read zero, the zero flag reads 1, and carry, overflow, sign and above-32 read 0.
- R2: An operation is taken on a rising clock edge where opValid is 1; accumulators, result and flags show its effect from that edge on. With opValid 0, with opcode 0 (no-op), or with an opcode from 27 to 31, every output keeps its value. Opcodes: 1 add other, 2 sub other, 3 add secondary, 4 sub secondary, 5 add half, 6 sub half, 7 add low unsigned, 8 add product, 9 sub product, 10 add imm16, 11 add imm8, 12 mid increment, 13 mid decrement, 14 increment, 15 decrement, 16 negate, 17 absolute, 18 clear, 19 test, 20 move other, 21 move secondary, 22 move half, 23 compare acc0 with acc1, 24 compare with secondary high half, 25 compare imm16, 26 compare imm8.
- R3: Add/sub with the other accumulator, with the full secondary register (selected by srcSel bit 0, sign-extended from 32 to 40 bits) or with the product write the 40-bit wrapped sum or difference into the accumulator named by dstSel and to result.
- R4: For the half forms srcSel picks a 16-bit half (0: low of secondary 0, 1: low of secondary 1, 2: high of secondary 0, 3: high of secondary 1), which is sign-extended and shifted left by 16 before the add or subtract.
- R5: The 16-bit and 8-bit immediates are each sign-extended and shifted left by 16 before being added or compared.
- R6: Add-low adds the low 16 bits of the secondary register picked by srcSel bit 0 as an unsigned, zero-extended value.
- R7: Mid increment and mid decrement add or subtract 0x10000; plain increment and decrement use 1.
- R8: For adds, carry is 1 when the unsigned 40-bit result is less than the first operand; for subtracts and compares, carry is 1 when the first operand is unsigned greater than or equal to the result.
- R9: Overflow is 1 when both addends share a sign and the result sign differs; a subtract or compare is taken as an add of the two's-complement negated second operand.
- R10: Zero reports a result of 0, sign reports result bit 39, and above-32 reports that bits 39 to 31 of the result are not all equal.
- R11: Compares update result and all flags but leave both accumulators unchanged; opcode 23 always computes acc0 minus acc1 whatever dstSel is, and opcode 24 subtracts the high half of the secondary picked by srcSel bit 0, shifted left by 16.
- R12: Negate writes the two's complement; absolute value negates only negative values, so the most negative value 0x80_0000_0000 is returned unchanged; both clear carry and overflow.
- R13: Clear writes zero and leaves zero flag 1; test reports the flags of the destination without writing; the three moves copy their source; move-half writes the aligned half with bits 15:0 zero; all five clear carry and overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Decoded operation code |
| dstSel | input | 1 | Destination accumulator |
| srcSel | input | 2 | Secondary register / half select |
| secReg0 | input | 32 | Secondary register 0 |
| secReg1 | input | 32 | Secondary register 1 |
| product | input | 40 | Product operand |
| immWide | input | 16 | 16-bit signed immediate |
| immShort | input | 8 | 8-bit signed immediate |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| result | output | 40 | Result of the last operation |
| carryFlag | output | 1 | Carry flag |
| overflowFlag | output | 1 | Overflow flag |
| zeroFlag | output | 1 | Zero flag |
| signFlag | output | 1 | Sign flag |
| above32Flag | output | 1 | Result exceeds signed 32-bit range |

## Verification
Every output of this unit is a register loaded at the rising edge that takes the operation, so each accumulator write, result and flag is due exactly one edge after the operation is presented. The bench presents an operation at a falling edge and compares all outputs at the next falling edge, half a cycle after that single rising edge, against a model it updates in the same step. Both accumulators are reloaded through clear and add-product before every swept operation, so each compare and hold check sees a known prior state.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP       = 5'd0,
    OP_ADD_ACC   = 5'd1,
    OP_SUB_ACC   = 5'd2,
    OP_ADD_SEC   = 5'd3,
    OP_SUB_SEC   = 5'd4,
    OP_ADD_HALF  = 5'd5,
    OP_SUB_HALF  = 5'd6,
    OP_ADD_LOW   = 5'd7,
    OP_ADD_PROD  = 5'd8,
    OP_SUB_PROD  = 5'd9,
    OP_ADD_IMM16 = 5'd10,
    OP_ADD_IMM8  = 5'd11,
    OP_INC_MID   = 5'd12,
    OP_DEC_MID   = 5'd13,
    OP_INC       = 5'd14,
    OP_DEC       = 5'd15,
    OP_NEG       = 5'd16,
    OP_ABS       = 5'd17,
    OP_CLR       = 5'd18,
    OP_TST       = 5'd19,
    OP_MOV_ACC   = 5'd20,
    OP_MOV_SEC   = 5'd21,
    OP_MOV_HALF  = 5'd22,
    OP_CMP01     = 5'd23,
    OP_CMP_HIGH  = 5'd24,
    OP_CMP_IMM16 = 5'd25,
    OP_CMP_IMM8  = 5'd26
  } op_e;

  localparam int OP_COUNT = 27;

  // Second-operand source
  typedef enum logic [3:0] {
    B_OTHER, B_ACC1, B_SEC, B_HALF, B_LOW, B_PROD,
    B_IMM16, B_IMM8, B_MIDONE, B_ONE, B_ZERO, B_HIGH
  } bSel_e;

  // How the result is formed
  typedef enum logic [2:0] {
    R_ADD, R_SUB, R_NEG, R_ABS, R_PASSA, R_PASSB
  } rMode_e;

  typedef struct packed {
    logic   apply;       // operation takes effect
    logic   writeBack;   // destination accumulator is written
    logic   arithFlags;  // carry/overflow from the adder, else cleared
    logic   aFromAcc0;   // first operand fixed to accumulator 0
    bSel_e  bSel;
    rMode_e rMode;
  } strobe_t;

  typedef struct packed {
    logic carry;
    logic overflow;
    logic zero;
    logic sign;
    logic above32;
  } flags_t;

endpackage

// File: rtl/acc_arith_ctrl.sv
module acc_arith_ctrl
  import acc_arith_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output strobe_t         strobes
);

  // Build an arithmetic strobe set
  function automatic strobe_t arithOp(bSel_e src, logic isSub, logic wb);
    strobe_t s;
    s.apply      = 1'b1;
    s.writeBack  = wb;
    s.arithFlags = 1'b1;
    s.aFromAcc0  = 1'b0;
    s.bSel       = src;
    s.rMode      = isSub ? R_SUB : R_ADD;
    return s;
  endfunction

  // Build a transfer / unary strobe set (carry and overflow cleared)
  function automatic strobe_t plainOp(bSel_e src, rMode_e mode, logic wb);
    strobe_t s;
    s.apply      = 1'b1;
    s.writeBack  = wb;
    s.arithFlags = 1'b0;
    s.aFromAcc0  = 1'b0;
    s.bSel       = src;
    s.rMode      = mode;
    return s;
  endfunction

  strobe_t decoded;

  always_comb begin
    decoded = '0;
    case (opCode)
      OP_ADD_ACC:   decoded = arithOp(B_OTHER,  1'b0, 1'b1);
      OP_SUB_ACC:   decoded = arithOp(B_OTHER,  1'b1, 1'b1);
      OP_ADD_SEC:   decoded = arithOp(B_SEC,    1'b0, 1'b1);
      OP_SUB_SEC:   decoded = arithOp(B_SEC,    1'b1, 1'b1);
      OP_ADD_HALF:  decoded = arithOp(B_HALF,   1'b0, 1'b1);
      OP_SUB_HALF:  decoded = arithOp(B_HALF,   1'b1, 1'b1);
      OP_ADD_LOW:   decoded = arithOp(B_LOW,    1'b0, 1'b1);
      OP_ADD_PROD:  decoded = arithOp(B_PROD,   1'b0, 1'b1);
      OP_SUB_PROD:  decoded = arithOp(B_PROD,   1'b1, 1'b1);
      OP_ADD_IMM16: decoded = arithOp(B_IMM16,  1'b0, 1'b1);
      OP_ADD_IMM8:  decoded = arithOp(B_IMM8,   1'b0, 1'b1);
      OP_INC_MID:   decoded = arithOp(B_MIDONE, 1'b0, 1'b1);
      OP_DEC_MID:   decoded = arithOp(B_MIDONE, 1'b1, 1'b1);
      OP_INC:       decoded = arithOp(B_ONE,    1'b0, 1'b1);
      OP_DEC:       decoded = arithOp(B_ONE,    1'b1, 1'b1);
      OP_NEG:       decoded = plainOp(B_ZERO,   R_NEG,   1'b1);
      OP_ABS:       decoded = plainOp(B_ZERO,   R_ABS,   1'b1);
      OP_CLR:       decoded = plainOp(B_ZERO,   R_PASSB, 1'b1);
      OP_TST:       decoded = plainOp(B_ZERO,   R_PASSA, 1'b0);
      OP_MOV_ACC:   decoded = plainOp(B_OTHER,  R_PASSB, 1'b1);
      OP_MOV_SEC:   decoded = plainOp(B_SEC,    R_PASSB, 1'b1);
      OP_MOV_HALF:  decoded = plainOp(B_HALF,   R_PASSB, 1'b1);
      OP_CMP01: begin
        decoded = arithOp(B_ACC1, 1'b1, 1'b0);
        decoded.aFromAcc0 = 1'b1;
      end
      OP_CMP_HIGH:  decoded = arithOp(B_HIGH,   1'b1, 1'b0);
      OP_CMP_IMM16: decoded = arithOp(B_IMM16,  1'b1, 1'b0);
      OP_CMP_IMM8:  decoded = arithOp(B_IMM8,   1'b1, 1'b0);
      default:      decoded = '0;
    endcase
  end

  always_comb begin
    strobes = decoded;
    strobes.apply = decoded.apply & opValid;
  end

endmodule

// File: rtl/acc_arith_datapath.sv
module acc_arith_datapath
  import acc_arith_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int SEC_W   = 32,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8,
  parameter int MID_POS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            ctl,
  input  logic               dstSel,
  input  logic [1:0]         srcSel,
  input  logic [SEC_W-1:0]   secReg0,
  input  logic [SEC_W-1:0]   secReg1,
  input  logic [ACC_W-1:0]   product,
  input  logic [HALF_W-1:0]  immWide,
  input  logic [SHORT_W-1:0] immShort,
  output logic [ACC_W-1:0]   accZero,
  output logic [ACC_W-1:0]   accOne,
  output logic [ACC_W-1:0]   resultOut,
  output flags_t             flagsOut
);

  localparam int NUM_ACC   = 2;
  localparam int HALF_EXT  = ACC_W - MID_POS - HALF_W;
  localparam int SHORT_EXT = ACC_W - MID_POS - SHORT_W;
  localparam int SEC_EXT   = ACC_W - SEC_W;
  localparam int LOW_EXT   = ACC_W - HALF_W;
  localparam int MSB       = ACC_W - 1;
  localparam int FIT_LSB   = SEC_W - 1;
  localparam logic [ACC_W-1:0] MID_ONE = ACC_W'(1) << MID_POS;

  logic [ACC_W-1:0] accReg [NUM_ACC];
  logic [ACC_W-1:0] resultReg;
  flags_t           flagsReg;

  logic [SEC_W-1:0]  secPick;
  logic [HALF_W-1:0] halfPick;
  logic [ACC_W-1:0]  aVal, bVal, otherVal, bEff, sumVal, negA, resVal;
  logic              isSub, carryNext, overflowNext;
  flags_t            flagsNext;

  function automatic logic [ACC_W-1:0] alignHalf(logic [HALF_W-1:0] v);
    return {{HALF_EXT{v[HALF_W-1]}}, v, {MID_POS{1'b0}}};
  endfunction

  function automatic logic [ACC_W-1:0] alignShort(logic [SHORT_W-1:0] v);
    return {{SHORT_EXT{v[SHORT_W-1]}}, v, {MID_POS{1'b0}}};
  endfunction

  // Operand selection and alignment
  always_comb begin
    secPick  = srcSel[0] ? secReg1 : secReg0;
    halfPick = srcSel[1] ? secPick[SEC_W-1:HALF_W] : secPick[HALF_W-1:0];
    aVal     = ctl.aFromAcc0 ? accReg[0] : accReg[dstSel];
    otherVal = accReg[!dstSel];
    case (ctl.bSel)
      B_OTHER:  bVal = otherVal;
      B_ACC1:   bVal = accReg[1];
      B_SEC:    bVal = {{SEC_EXT{secPick[SEC_W-1]}}, secPick};
      B_HALF:   bVal = alignHalf(halfPick);
      B_LOW:    bVal = {{LOW_EXT{1'b0}}, secPick[HALF_W-1:0]};
      B_PROD:   bVal = product;
      B_IMM16:  bVal = alignHalf(immWide);
      B_IMM8:   bVal = alignShort(immShort);
      B_MIDONE: bVal = MID_ONE;
      B_ONE:    bVal = ACC_W'(1);
      B_HIGH:   bVal = alignHalf(secPick[SEC_W-1:HALF_W]);
      default:  bVal = '0;
    endcase
  end

  // One shared adder; subtract adds the negated operand
  always_comb begin
    isSub  = (ctl.rMode == R_SUB);
    bEff   = isSub ? (~bVal + ACC_W'(1)) : bVal;
    sumVal = aVal + bEff;
    negA   = ~aVal + ACC_W'(1);
    case (ctl.rMode)
      R_ADD, R_SUB: resVal = sumVal;
      R_NEG:        resVal = negA;
      R_ABS:        resVal = aVal[MSB] ? negA : aVal;
      R_PASSA:      resVal = aVal;
      R_PASSB:      resVal = bVal;
      default:      resVal = '0;
    endcase
    carryNext    = isSub ? (aVal >= sumVal) : (sumVal < aVal);
    overflowNext = (aVal[MSB] == bEff[MSB]) && (sumVal[MSB] != aVal[MSB]);
  end

  always_comb begin
    flagsNext.carry    = ctl.arithFlags & carryNext;
    flagsNext.overflow = ctl.arithFlags & overflowNext;
    flagsNext.zero     = (resVal == '0);
    flagsNext.sign     = resVal[MSB];
    flagsNext.above32  = !((&resVal[MSB:FIT_LSB]) || !(|resVal[MSB:FIT_LSB]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) accReg[i] <= '0;
      resultReg <= '0;
      flagsReg  <= '{carry: 1'b0, overflow: 1'b0, zero: 1'b1, sign: 1'b0, above32: 1'b0};
    end else if (ctl.apply) begin
      for (int i = 0; i < NUM_ACC; i++) begin
        if (ctl.writeBack && (int'(dstSel) == i)) accReg[i] <= resVal;
      end
      resultReg <= resVal;
      flagsReg  <= flagsNext;
    end
  end

  assign accZero   = accReg[0];
  assign accOne    = accReg[1];
  assign resultOut = resultReg;
  assign flagsOut  = flagsReg;

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_arith_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int SEC_W   = 32,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8,
  parameter int MID_POS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opValid,
  input  logic [OP_W-1:0]    opCode,
  input  logic               dstSel,
  input  logic [1:0]         srcSel,
  input  logic [SEC_W-1:0]   secReg0,
  input  logic [SEC_W-1:0]   secReg1,
  input  logic [ACC_W-1:0]   product,
  input  logic [HALF_W-1:0]  immWide,
  input  logic [SHORT_W-1:0] immShort,
  output logic [ACC_W-1:0]   acc0,
  output logic [ACC_W-1:0]   acc1,
  output logic [ACC_W-1:0]   result,
  output logic               carryFlag,
  output logic               overflowFlag,
  output logic               zeroFlag,
  output logic               signFlag,
  output logic               above32Flag
);

  strobe_t strobes;
  flags_t  flags;

  acc_arith_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  acc_arith_datapath #(
    .ACC_W   (ACC_W),
    .SEC_W   (SEC_W),
    .HALF_W  (HALF_W),
    .SHORT_W (SHORT_W),
    .MID_POS (MID_POS)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (strobes),
    .dstSel    (dstSel),
    .srcSel    (srcSel),
    .secReg0   (secReg0),
    .secReg1   (secReg1),
    .product   (product),
    .immWide   (immWide),
    .immShort  (immShort),
    .accZero   (acc0),
    .accOne    (acc1),
    .resultOut (result),
    .flagsOut  (flags)
  );

  assign carryFlag    = flags.carry;
  assign overflowFlag = flags.overflow;
  assign zeroFlag     = flags.zero;
  assign signFlag     = flags.sign;
  assign above32Flag  = flags.above32;

endmodule

// File: rtl/acc_arith_checker.sv
module acc_arith_checker
  import acc_arith_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             opValid,
  input logic [OP_W-1:0]  opCode,
  input logic             dstSel,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic [ACC_W-1:0] result,
  input logic             carryFlag,
  input logic             overflowFlag,
  input logic             zeroFlag,
  input logic             signFlag
);

  localparam logic [ACC_W-1:0] MOST_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic isCompare;
  assign isCompare = (opCode == OP_CMP01) || (opCode == OP_CMP_HIGH) ||
                     (opCode == OP_CMP_IMM16) || (opCode == OP_CMP_IMM8);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> $stable(acc0) && $stable(acc1) && $stable(result) &&
                 $stable(carryFlag) && $stable(overflowFlag) && $stable(zeroFlag));

  assert_inc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && (opCode == OP_INC) && !dstSel |=> acc0 == $past(acc0) + ACC_W'(1));

  assert_zero_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zeroFlag == (result == '0));

  assert_sign_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    signFlag == result[ACC_W-1]);

  assert_cmp_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && isCompare |=> $stable(acc0) && $stable(acc1));

  assert_abs_nonneg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && (opCode == OP_ABS) |=> !signFlag || (result == MOST_NEG));

  assert_unary_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && ((opCode == OP_NEG) || (opCode == OP_ABS)) |=> !carryFlag && !overflowFlag);

  assert_clear_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && (opCode == OP_CLR) |=> zeroFlag && !carryFlag && !overflowFlag);

  assert_movhalf_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && (opCode == OP_MOV_HALF) |=> result[15:0] == 16'h0000);

endmodule

bind acc_arith_unit acc_arith_checker #(.ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .opValid      (opValid),
  .opCode       (opCode),
  .dstSel       (dstSel),
  .acc0         (acc0),
  .acc1         (acc1),
  .result       (result),
  .carryFlag    (carryFlag),
  .overflowFlag (overflowFlag),
  .zeroFlag     (zeroFlag),
  .signFlag     (signFlag)
);

// File: tb/acc_arith_unit_test.sv
module acc_arith_unit_test;
  import acc_arith_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic        dstSel = 1'b0;
  logic [1:0]  srcSel = '0;
  logic [31:0] secReg0 = '0, secReg1 = '0;
  logic [39:0] product = '0;
  logic [15:0] immWide = '0;
  logic [7:0]  immShort = '0;
  logic [39:0] acc0, acc1, result;
  logic        carryFlag, overflowFlag, zeroFlag, signFlag, above32Flag;

  int vectors = 0;
  int miscompares = 0;

  // Bench model state
  logic [39:0] mAcc [2];
  logic [39:0] mRes;
  logic        mC, mV, mZ, mS, mA;

  acc_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .dstSel(dstSel), .srcSel(srcSel), .secReg0(secReg0), .secReg1(secReg1),
    .product(product), .immWide(immWide), .immShort(immShort),
    .acc0(acc0), .acc1(acc1), .result(result), .carryFlag(carryFlag),
    .overflowFlag(overflowFlag), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .above32Flag(above32Flag)
  );

  always #4 clk = ~clk;

  function automatic longint sx40(logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  function automatic logic [39:0] atMid(longint v);
    longint t;
    t = v * 65536;
    return t[39:0];
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishModel(logic d, logic [39:0] r, logic wb, logic c, logic v);
    longint t;
    t = sx40(r);
    mRes = r;
    mC = c;
    mV = v;
    mZ = (r == 40'h0);
    mS = r[39];
    mA = (t > 64'sh7FFF_FFFF) || (t < -64'sh8000_0000);
    if (wb) mAcc[d] = r;
  endtask

  task automatic modelArith(logic d, logic [39:0] a, logic [39:0] b, logic sub, logic wb);
    logic [39:0] nb, r;
    longint t;
    logic c, v;
    nb = sub ? 40'(-sx40(b)) : b;
    t  = sx40(a) + sx40(nb);
    r  = t[39:0];
    c  = sub ? (a >= r) : (r < a);
    v  = (t > 64'sh7F_FFFF_FFFF) || (t < -64'sh80_0000_0000);
    finishModel(d, r, wb, c, v);
  endtask

  task automatic modelOp(op_e op, logic d, logic [1:0] s);
    logic [39:0] a, other, secFull, half, hi, low, i16, i8;
    logic [31:0] sp;
    logic [15:0] hp;
    a     = mAcc[d];
    other = mAcc[!d];
    sp    = s[0] ? secReg1 : secReg0;
    hp    = s[1] ? sp[31:16] : sp[15:0];
    secFull = 40'(longint'($signed(sp)));
    half  = atMid(longint'($signed(hp)));
    hi    = atMid(longint'($signed(sp[31:16])));
    low   = {24'h0, sp[15:0]};
    i16   = atMid(longint'($signed(immWide)));
    i8    = atMid(longint'($signed(immShort)));
    case (op)
      OP_ADD_ACC:   modelArith(d, a, other, 1'b0, 1'b1);
      OP_SUB_ACC:   modelArith(d, a, other, 1'b1, 1'b1);
      OP_ADD_SEC:   modelArith(d, a, secFull, 1'b0, 1'b1);
      OP_SUB_SEC:   modelArith(d, a, secFull, 1'b1, 1'b1);
      OP_ADD_HALF:  modelArith(d, a, half, 1'b0, 1'b1);
      OP_SUB_HALF:  modelArith(d, a, half, 1'b1, 1'b1);
      OP_ADD_LOW:   modelArith(d, a, low, 1'b0, 1'b1);
      OP_ADD_PROD:  modelArith(d, a, product, 1'b0, 1'b1);
      OP_SUB_PROD:  modelArith(d, a, product, 1'b1, 1'b1);
      OP_ADD_IMM16: modelArith(d, a, i16, 1'b0, 1'b1);
      OP_ADD_IMM8:  modelArith(d, a, i8, 1'b0, 1'b1);
      OP_INC_MID:   modelArith(d, a, 40'h1_0000, 1'b0, 1'b1);
      OP_DEC_MID:   modelArith(d, a, 40'h1_0000, 1'b1, 1'b1);
      OP_INC:       modelArith(d, a, 40'h1, 1'b0, 1'b1);
      OP_DEC:       modelArith(d, a, 40'h1, 1'b1, 1'b1);
      OP_NEG:       finishModel(d, 40'(-sx40(a)), 1'b1, 1'b0, 1'b0);
      OP_ABS:       finishModel(d, (sx40(a) < 0) ? 40'(-sx40(a)) : a, 1'b1, 1'b0, 1'b0);
      OP_CLR:       finishModel(d, 40'h0, 1'b1, 1'b0, 1'b0);
      OP_TST:       finishModel(d, a, 1'b0, 1'b0, 1'b0);
      OP_MOV_ACC:   finishModel(d, other, 1'b1, 1'b0, 1'b0);
      OP_MOV_SEC:   finishModel(d, secFull, 1'b1, 1'b0, 1'b0);
      OP_MOV_HALF:  finishModel(d, half, 1'b1, 1'b0, 1'b0);
      OP_CMP01:     modelArith(d, mAcc[0], mAcc[1], 1'b1, 1'b0);
      OP_CMP_HIGH:  modelArith(d, a, hi, 1'b1, 1'b0);
      OP_CMP_IMM16: modelArith(d, a, i16, 1'b1, 1'b0);
      OP_CMP_IMM8:  modelArith(d, a, i8, 1'b1, 1'b0);
      default: ;
    endcase
  endtask

  function automatic string tagOf(op_e op);
    case (op)
      OP_ADD_HALF, OP_SUB_HALF:                        return "R4";
      OP_ADD_IMM16, OP_ADD_IMM8:                       return "R5";
      OP_ADD_LOW:                                      return "R6";
      OP_INC_MID, OP_DEC_MID, OP_INC, OP_DEC:          return "R7";
      OP_NEG, OP_ABS:                                  return "R12";
      OP_CMP01, OP_CMP_HIGH, OP_CMP_IMM16, OP_CMP_IMM8: return "R11";
      OP_CLR, OP_TST, OP_MOV_ACC, OP_MOV_SEC, OP_MOV_HALF: return "R13";
      OP_NOP:                                          return "R2";
      default:                                         return "R3";
    endcase
  endfunction

  task automatic compareAll(string tag);
    check(tag, "acc0", 64'(acc0), 64'(mAcc[0]));
    check(tag, "acc1", 64'(acc1), 64'(mAcc[1]));
    check(tag, "result", 64'(result), 64'(mRes));
    check("R8", "carry", 64'(carryFlag), 64'(mC));
    check("R9", "overflow", 64'(overflowFlag), 64'(mV));
    check("R10", "zero", 64'(zeroFlag), 64'(mZ));
    check("R10", "sign", 64'(signFlag), 64'(mS));
    check("R10", "above32", 64'(above32Flag), 64'(mA));
  endtask

  // Called at a falling edge; compares at the next falling edge
  task automatic doOp(op_e op, logic d, logic [1:0] s);
    opValid = 1'b1;
    opCode  = op;
    dstSel  = d;
    srcSel  = s;
    modelOp(op, d, s);
    @(negedge clk);
    compareAll(tagOf(op));
  endtask

  function automatic logic [39:0] pat(int k);
    logic [63:0] h;
    case (k % 24)
      0: return 40'h00_0000_0000;
      1: return 40'h00_0000_0001;
      2: return 40'hFF_FFFF_FFFF;
      3: return 40'h80_0000_0000;
      4: return 40'h7F_FFFF_FFFF;
      5: return 40'h00_7FFF_FFFF;
      6: return 40'hFF_8000_0000;
      7: return 40'h00_0001_0000;
      8: return 40'h00_8000_8000;
      9: return 40'hFF_FFFF_0000;
      default: begin
        h = 64'(k) * 64'h9E37_79B9_7F4A_7C15;
        return h[51:12];
      end
    endcase
  endfunction

  initial begin
    mAcc[0] = '0; mAcc[1] = '0; mRes = '0;
    mC = 1'b0; mV = 1'b0; mZ = 1'b1; mS = 1'b0; mA = 1'b0;
    repeat (3) @(negedge clk);
    compareAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2: idle, no-op and undefined opcodes leave everything alone
    product = 40'h12_3456_7890;
    doOp(OP_ADD_PROD, 1'b0, 2'd0);
    opValid = 1'b0; opCode = OP_INC;
    @(negedge clk);
    compareAll("R2");
    for (int u = 27; u < 32; u++) begin
      opValid = 1'b1; opCode = 5'(u);
      @(negedge clk);
      compareAll("R2");
    end

    // Near-exhaustive sweep: every opcode, destination and source select
    for (int p = 0; p < 24; p++) begin
      secReg0  = pat(p + 1)[31:0];
      secReg1  = pat(p + 5)[39:8];
      immWide  = pat(p + 2)[31:16];
      immShort = pat(p + 4)[39:32];
      for (int k = 0; k < OP_COUNT; k++) begin
        for (int d = 0; d < 2; d++) begin
          for (int s = 0; s < 4; s++) begin
            product = pat(p);
            doOp(OP_CLR, 1'b0, 2'd0);
            doOp(OP_ADD_PROD, 1'b0, 2'd0);
            product = pat(p + 3);
            doOp(OP_CLR, 1'b1, 2'd0);
            doOp(OP_ADD_PROD, 1'b1, 2'd0);
            product = pat(p + 7);
            doOp(op_e'(5'(k)), d[0], 2'(s));
          end
        end
      end
    end

    opValid = 1'b0;
    @(negedge clk);
    compareAll("R2");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule